// File: doc/BRIEF.md
# Operand Bypass and Interlock Controller

This block is the hazard controller for a five-stage integer pipeline: fetch, decode with register read, execute, memory access and writeback. It reads the instruction held in decode and the one in execute, together with the destination and write-enable information held in the two later pipeline registers. From these it produces the select codes for the operand bypass multiplexers and a single interlock signal. The register file, the ALU and the memories sit outside the block; only register numbers and the control bits that describe each stage reach it.

Results are bypassed to both ALU inputs in execute and to the store-data path in the memory stage. They are also bypassed to both inputs of the equality comparator in decode, so that branches resolve there. The interlock is raised for the read-after-write cases that bypassing cannot cover. While it is high, the surrounding pipeline holds the program counter and the fetch/decode register and loads a no-op into the decode/execute register. A branch is followed by one delay slot that always runs, so the block never squashes anything. Registers are read in stage 2 and written in stage 5, so only read-after-write dependences need any action.

Top module: `hazard_unit`

## Requirements
- R1: Source register one is taken from instruction bits 25:21 and source register two from bits 20:16. An instruction in execute writes the register named at bits 15:11 when `ex_reg_form` is 1, and the one at bits 20:16 when it is 0.
- R2: Select code 2'b10 picks the result held after execute, 2'b01 the result held after memory, and 2'b00 the register-file value. Code 2'b11 never appears. A writing instruction in the memory stage whose destination equals an execute source gives 2'b10 for that operand.
- R3: When only the instruction in writeback writes the execute source, that operand's select is 2'b01.
- R4: When both later stages write the same source, the memory-stage result (2'b10) wins.
- R5: A destination or source of register 0, or a stage with its write enable low, never causes a bypass or an interlock.
- R6: A load in execute whose destination is read by the instruction in decode raises `stall` for that cycle.
- R7: When the decode instruction is a store that needs the load's destination only as its data (the second source), no interlock is raised. A store in the memory stage whose data register equals the writeback destination gets `fwd_st` = 2'b01. Otherwise `fwd_st` is 2'b00.
- R8: A branch in decode gets comparator selects by the same rules as R2 to R4. It is interlocked while any writing instruction in execute targets one of its sources, and also while a load in the memory stage does. A branch waiting on an ALU result therefore loses one cycle, and one waiting on a load loses two.
- R9: In every other case `stall` is 0. In particular, non-branch instructions that depend on ALU results run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_instr | input | 32 | Instruction word in decode |
| id_rd_rs | input | 1 | Decode instruction reads source one |
| id_rd_rt | input | 1 | Decode instruction reads source two |
| id_branch | input | 1 | Decode instruction is a conditional branch |
| id_store | input | 1 | Decode instruction is a store |
| ex_instr | input | 32 | Instruction word in execute |
| ex_reg_form | input | 1 | Execute instruction is register-register (destination at 15:11) |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_dst | input | 5 | Destination held after execute |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| mem_store | input | 1 | Memory-stage instruction is a store |
| mem_rt | input | 5 | Data register of the memory-stage store |
| wb_dst | input | 5 | Destination held after memory |
| wb_wen | input | 1 | Writeback instruction writes a register |
| fwd_a | output | 2 | Select for ALU operand one |
| fwd_b | output | 2 | Select for ALU operand two |
| fwd_st | output | 2 | Select for store data in memory stage |
| fwd_br_a | output | 2 | Select for comparator input one in decode |
| fwd_br_b | output | 2 | Select for comparator input two in decode |
| stall | output | 1 | Hold PC and fetch/decode, load a no-op into decode/execute |

## Verification
The block is purely combinational, so a wrong match or priority shows on a select or on `stall` in the same cycle the offending register numbers are presented. No hidden state can delay a fault. A register-field slip or a missing zero-register guard shows as a select pointing at a stage that does not hold the operand. A wrong interlock term shows either as a missing `stall`, which lets a stale value be used, or as a spurious one, which costs a cycle. A sweep over a small set of register numbers, including 0 and 31, together with every combination of stage flags, catches each such fault directly.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  localparam int INSTR_W   = 32;
  localparam int REG_W     = 5;
  localparam int SRC1_LSB  = 21;
  localparam int SRC2_LSB  = 16;
  localparam int DSTR_LSB  = 11;

  typedef logic [REG_W-1:0]   reg_idx_t;
  typedef logic [INSTR_W-1:0] instr_t;

  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } fwd_sel_e;

  function automatic reg_idx_t src1_of(instr_t ins);
    return ins[SRC1_LSB +: REG_W];
  endfunction

  function automatic reg_idx_t src2_of(instr_t ins);
    return ins[SRC2_LSB +: REG_W];
  endfunction

  // register-register forms name the target in the third field
  function automatic reg_idx_t dst_of(instr_t ins, logic reg_form);
    return reg_form ? ins[DSTR_LSB +: REG_W] : ins[SRC2_LSB +: REG_W];
  endfunction

  // a producer feeds a consumer only if it writes a real register
  function automatic logic hits(logic wen, reg_idx_t dst, reg_idx_t src);
    return wen && (dst != '0) && (dst == src);
  endfunction
endpackage

// File: rtl/fwd_select.sv
module fwd_select
  import hazard_pkg::*;
(
  input  reg_idx_t src,
  input  reg_idx_t mem_dst,
  input  logic     mem_wen,
  input  reg_idx_t wb_dst,
  input  logic     wb_wen,
  output fwd_sel_e sel
);
  logic mem_hit;
  logic wb_hit;

  assign mem_hit = hits(mem_wen, mem_dst, src);
  assign wb_hit  = hits(wb_wen, wb_dst, src);

  always_comb begin
    if (mem_hit)     sel = SEL_MEM;
    else if (wb_hit) sel = SEL_WB;
    else             sel = SEL_RF;
  end

  always_comb begin
    AST_SEL_CODE_LEGAL: assert (sel != 2'b11) else $error("illegal select code"); // R2
    if (src == '0) begin
      AST_ZERO_SRC_FROM_RF: assert (sel == SEL_RF) else $error("zero register bypassed"); // R5
    end
    if (!mem_wen && !wb_wen) begin
      AST_NO_WRITER_FROM_RF: assert (sel == SEL_RF) else $error("bypass without writer"); // R5
    end
  end
endmodule

// File: rtl/stall_detect.sv
module stall_detect
  import hazard_pkg::*;
(
  input  reg_idx_t id_rs,
  input  reg_idx_t id_rt,
  input  logic     id_rd_rs,
  input  logic     id_rd_rt,
  input  logic     id_branch,
  input  logic     id_store,
  input  reg_idx_t ex_dst,
  input  logic     ex_wen,
  input  logic     ex_load,
  input  reg_idx_t mem_dst,
  input  logic     mem_wen,
  input  logic     mem_load,
  output logic     stall
);
  logic rs_on_ex, rt_on_ex, rs_on_mem, rt_on_mem;
  logic load_use;
  logic br_on_ex;
  logic br_on_mem_load;

  assign rs_on_ex  = id_rd_rs && hits(ex_wen, ex_dst, id_rs);
  assign rt_on_ex  = id_rd_rt && hits(ex_wen, ex_dst, id_rt);
  assign rs_on_mem = id_rd_rs && hits(mem_wen, mem_dst, id_rs);
  assign rt_on_mem = id_rd_rt && hits(mem_wen, mem_dst, id_rt);

  // store data reaches the memory stage late enough to take the loaded value
  assign load_use       = ex_load && (rs_on_ex || (rt_on_ex && !id_store));
  assign br_on_ex       = id_branch && (rs_on_ex || rt_on_ex);
  assign br_on_mem_load = id_branch && mem_load && (rs_on_mem || rt_on_mem);

  assign stall = load_use || br_on_ex || br_on_mem_load;

  always_comb begin
    if (stall) begin
      AST_STALL_HAS_CAUSE: assert (ex_load || id_branch) else $error("stall without cause"); // R9
      AST_STALL_NEEDS_WRITER: assert (ex_wen || mem_wen) else $error("stall without writer"); // R5
    end
    if (!id_branch && id_store && !rs_on_ex) begin
      AST_STORE_DATA_NO_WAIT: assert (!stall) else $error("store data interlocked"); // R7
    end
  end
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
  import hazard_pkg::*;
(
  input  logic [31:0] id_instr,
  input  logic        id_rd_rs,
  input  logic        id_rd_rt,
  input  logic        id_branch,
  input  logic        id_store,
  input  logic [31:0] ex_instr,
  input  logic        ex_reg_form,
  input  logic        ex_wen,
  input  logic        ex_load,
  input  logic [4:0]  mem_dst,
  input  logic        mem_wen,
  input  logic        mem_load,
  input  logic        mem_store,
  input  logic [4:0]  mem_rt,
  input  logic [4:0]  wb_dst,
  input  logic        wb_wen,
  output logic [1:0]  fwd_a,
  output logic [1:0]  fwd_b,
  output logic [1:0]  fwd_st,
  output logic [1:0]  fwd_br_a,
  output logic [1:0]  fwd_br_b,
  output logic        stall
);
  localparam int N_PORTS = 4;

  reg_idx_t id_rs, id_rt, ex_rs, ex_rt, ex_dst, st_src;
  reg_idx_t port_src [N_PORTS];
  fwd_sel_e port_sel [N_PORTS];
  fwd_sel_e st_sel;
  logic     unused_bits;

  assign id_rs  = src1_of(id_instr);
  assign id_rt  = src2_of(id_instr);
  assign ex_rs  = src1_of(ex_instr);
  assign ex_rt  = src2_of(ex_instr);
  assign ex_dst = dst_of(ex_instr, ex_reg_form);
  assign unused_bits = ^{id_instr[31:26], id_instr[15:0], ex_instr[31:26], ex_instr[10:0]};

  assign port_src[0] = ex_rs;
  assign port_src[1] = ex_rt;
  assign port_src[2] = id_rs;
  assign port_src[3] = id_rt;

  // ALU operands in execute and comparator inputs in decode share one rule
  for (genvar g = 0; g < N_PORTS; g++) begin : g_port
    fwd_select u_sel (
      .src     (port_src[g]),
      .mem_dst (mem_dst),
      .mem_wen (mem_wen),
      .wb_dst  (wb_dst),
      .wb_wen  (wb_wen),
      .sel     (port_sel[g])
    );
  end

  // store data only ever comes from the writeback register
  assign st_src = mem_store ? mem_rt : '0;

  fwd_select u_st_sel (
    .src     (st_src),
    .mem_dst ('0),
    .mem_wen (1'b0),
    .wb_dst  (wb_dst),
    .wb_wen  (wb_wen),
    .sel     (st_sel)
  );

  stall_detect u_stall (
    .id_rs     (id_rs),
    .id_rt     (id_rt),
    .id_rd_rs  (id_rd_rs),
    .id_rd_rt  (id_rd_rt),
    .id_branch (id_branch),
    .id_store  (id_store),
    .ex_dst    (ex_dst),
    .ex_wen    (ex_wen),
    .ex_load   (ex_load),
    .mem_dst   (mem_dst),
    .mem_wen   (mem_wen),
    .mem_load  (mem_load),
    .stall     (stall)
  );

  assign fwd_a    = port_sel[0];
  assign fwd_b    = port_sel[1];
  assign fwd_br_a = port_sel[2];
  assign fwd_br_b = port_sel[3];
  assign fwd_st   = st_sel;

  always_comb begin
    if (fwd_st != 2'b00) begin
      AST_STORE_SEL_ONLY_STORE: assert (mem_store && wb_wen) else $error("store bypass misfire"); // R7
    end
    if (stall && !id_branch) begin
      AST_NONBRANCH_STALL_IS_LOAD: assert (ex_load && ex_wen) else $error("non-load interlock"); // R6
    end
  end
endmodule

// File: tb/hazard_unit_tb.sv
module hazard_unit_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] id_instr, ex_instr;
  logic id_rd_rs, id_rd_rt, id_branch, id_store;
  logic ex_reg_form, ex_wen, ex_load;
  logic [4:0] mem_dst, mem_rt, wb_dst;
  logic mem_wen, mem_load, mem_store, wb_wen;
  logic [1:0] fwd_a, fwd_b, fwd_st, fwd_br_a, fwd_br_b;
  logic stall;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  hazard_unit u_dut (.*);

  function automatic logic [4:0] regsel(int i);
    return (i == 3) ? 5'd31 : 5'(i);
  endfunction

  // independent statement of R2/R3/R4/R5
  function automatic logic [1:0] exp_sel(logic [4:0] s, logic [4:0] m, logic mw,
                                         logic [4:0] w, logic ww);
    if (s == 0) return 2'd0;
    if (mw && m == s) return 2'd2;
    if (ww && w == s) return 2'd1;
    return 2'd0;
  endfunction

  task automatic chk(string req, string what, logic [1:0] act, logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic string sel_tag(logic [4:0] s, logic [4:0] m, logic mw,
                                    logic [4:0] w, logic ww);
    logic hm, hw;
    hm = mw && m == s;
    hw = ww && w == s;
    if (s == 0) return "R5";
    if (hm && hw) return "R4";
    if (hm) return "R2";
    if (hw) return "R3";
    return "R1";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    id_instr = '0; ex_instr = '0; id_rd_rs = 0; id_rd_rt = 0; id_branch = 0; id_store = 0;
    ex_reg_form = 0; ex_wen = 0; ex_load = 0; mem_dst = 0; mem_wen = 0; mem_load = 0;
    mem_store = 0; mem_rt = 0; wb_dst = 0; wb_wen = 0;
    @(negedge clk);
    // idle state: nothing selected, no interlock (R5, R9)
    chk("R5", "idle fwd_a", fwd_a, 2'd0);
    chk("R5", "idle fwd_b", fwd_b, 2'd0);
    chk("R5", "idle fwd_st", fwd_st, 2'd0);
    chk("R9", "idle stall", {1'b0, stall}, 2'd0);

    // sweep 1: bypass selects for execute, decode comparator and store data
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int m = 0; m < 4; m++)
          for (int w = 0; w < 4; w++)
            for (int fl = 0; fl < 4; fl++) begin
              logic [4:0] ra, rb, rm, rw;
              logic mw, ww;
              ra = regsel(a); rb = regsel(b); rm = regsel(m); rw = regsel(w);
              mw = fl[0]; ww = fl[1];
              ex_instr  = {6'h00, ra, rb, 5'd23, 11'h5a5};
              id_instr  = {6'h04, ra, rb, 16'hbeef};
              ex_reg_form = 1; ex_wen = 0; ex_load = 0; id_branch = 0; id_store = 0;
              id_rd_rs = 1; id_rd_rt = 1;
              mem_dst = rm; mem_wen = mw; mem_load = 0; wb_dst = rw; wb_wen = ww;
              mem_store = 1; mem_rt = ra;
              #3;
              chk(sel_tag(ra, rm, mw, rw, ww), "fwd_a", fwd_a, exp_sel(ra, rm, mw, rw, ww));
              chk(sel_tag(rb, rm, mw, rw, ww), "fwd_b", fwd_b, exp_sel(rb, rm, mw, rw, ww));
              chk("R8", "fwd_br_a", fwd_br_a, exp_sel(ra, rm, mw, rw, ww));
              chk("R8", "fwd_br_b", fwd_br_b, exp_sel(rb, rm, mw, rw, ww));
              chk("R7", "fwd_st", fwd_st, exp_sel(ra, 5'd0, 1'b0, rw, ww));
              mem_store = 0;
              #2;
              chk("R7", "fwd_st idle", fwd_st, 2'd0);
            end

    // sweep 2: interlock
    for (int s1 = 0; s1 < 4; s1++)
      for (int s2 = 0; s2 < 4; s2++)
        for (int e = 0; e < 4; e++)
          for (int m = 0; m < 4; m++)
            for (int fl = 0; fl < 256; fl++) begin
              logic [4:0] rs, rt, re, rm;
              logic el, ew, br, st, ml, mw, urs, urt, rf;
              logic hit_s1, hit_s2, hm_s1, hm_s2, exp_st;
              string tag;
              rs = regsel(s1); rt = regsel(s2); re = regsel(e); rm = regsel(m);
              {urt, urs, mw, ml, st, br, ew, el} = 8'(fl);
              rf = e[0] ^ s1[0];
              id_instr = {6'h2b, rs, rt, 16'h1234};
              ex_instr = rf ? {6'h00, 5'd23, 5'd23, re, 11'h000}
                            : {6'h23, 5'd23, re, 16'hbeef};
              ex_reg_form = rf; ex_wen = ew; ex_load = el;
              id_rd_rs = urs; id_rd_rt = urt; id_branch = br; id_store = st;
              mem_dst = rm; mem_wen = mw; mem_load = ml; mem_store = 0; mem_rt = 0;
              wb_dst = 0; wb_wen = 0;
              hit_s1 = urs && ew && re != 0 && re == rs;
              hit_s2 = urt && ew && re != 0 && re == rt;
              hm_s1  = urs && mw && ml && rm != 0 && rm == rs;
              hm_s2  = urt && mw && ml && rm != 0 && rm == rt;
              exp_st = 0;
              tag = "R9";
              if (br && (hit_s1 || hit_s2)) begin exp_st = 1; tag = "R8"; end
              else if (br && (hm_s1 || hm_s2)) begin exp_st = 1; tag = "R8"; end
              else if (el && hit_s1) begin exp_st = 1; tag = "R6"; end
              else if (el && hit_s2 && !st) begin exp_st = 1; tag = "R6"; end
              else if (el && hit_s2 && st) tag = "R7";
              else if (re != 0 && re == rs) tag = "R1";
              #2;
              chk(tag, "stall", {1'b0, stall}, {1'b0, exp_st});
            end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule